// File: doc/BRIEF.md
# Raster Frame Timing Generator

This block is the timing core of a tile-based video processor. On every pixel clock it moves a dot counter and a line counter across a fixed raster of 341 dots per line and 262 lines per frame. From the current position it decodes which work window the rest of the video pipeline should be in: fetching tiles and emitting pixels, loading sprites for the next line, or prefetching the first tiles of the next line. It also gives the column and row of the pixel being produced.

The frame has four kinds of line. Lines 0 to 239 form the visible 256 by 240 image. Line 240 is idle. Lines 241 to 260 are vertical blank. Line 261 prepares the first visible line. When vertical blank starts, the block sets a status flag. It requests a non-maskable interrupt while that flag and an enable input are both high. The flag is cleared when software reads the status register, which the surrounding logic signals through a clear input, and it is also cleared automatically on the preparation line. A one-clock pulse marks the start of each new frame.

Top module: `raster_timing_gen`

## Requirements
- R1: `dot_o` counts 0, 1, ..., 340 with one step per clock, and returns to 0 on the clock after it shows 340.
- R2: `line_o` holds its value except on the clock where `dot_o` leaves 340. There it steps by one, and after 261 it returns to 0.
- R3: While reset is held, and in the first cycle after it is released, `dot_o` and `line_o` are 0 and `vblank_o`, `nmi_o` and `frame_done_o` are 0, whatever the state of the enable input.
- R4: On lines 0 to 239 and on line 261, `fetch_o` is high exactly at dots 1 to 256, `sprite_o` at dots 257 to 320 and `prefetch_o` at dots 321 to 340. All three are low at dot 0, and low on every dot of lines 240 to 260.
- R5: `visible_o` is high exactly on lines 0 to 239 at dots 1 to 256. While it is high, `px_x_o` equals `dot_o` minus 1 and `px_y_o` equals `line_o`. Otherwise both are 0.
- R6: `vblank_o` becomes 1 in the cycle where the counters show line 241, dot 1, which is the clock after line 241, dot 0.
- R7: If `vblank_clr_i` is high at a clock edge, `vblank_o` is 0 after that edge. The one exception is the edge that leaves line 241, dot 0: there the set wins and `vblank_o` becomes 1.
- R8: `vblank_o` becomes 0 in the cycle where the counters show line 261, dot 2, which is the clock after line 261, dot 1.
- R9: `nmi_o` equals `vblank_o` AND `nmi_en_i` with no register in between. Raising the enable while the flag is set raises `nmi_o` in the same cycle.
- R10: `frame_done_o` is high for exactly the one cycle in which the counters show line 0, dot 0 after a wrap from line 261, dot 340. It is low in that position right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_en_i | input | 1 | Interrupt request enable |
| vblank_clr_i | input | 1 | Clears the vertical-blank flag (status read) |
| dot_o | output | 9 | Current dot within the line, 0 to 340 |
| line_o | output | 9 | Current line within the frame, 0 to 261 |
| fetch_o | output | 1 | Tile fetch / pixel output window |
| sprite_o | output | 1 | Sprite load window |
| prefetch_o | output | 1 | Next-line prefetch window |
| visible_o | output | 1 | A visible pixel is being produced |
| px_x_o | output | 8 | Pixel column while visible |
| px_y_o | output | 8 | Pixel row while visible |
| vblank_o | output | 1 | Vertical-blank status flag |
| nmi_o | output | 1 | Interrupt request |
| frame_done_o | output | 1 | One-clock start-of-frame pulse |

## Verification
The flag assertions assume that `vblank_clr_i` and `nmi_en_i` are synchronous to the pixel clock and settle before each edge. They do not assume anything about pulse width, so a clear may be held for many cycles. The stimulus changes both inputs one nanosecond after a rising edge. It holds the clear across the vertical-blank set point to exercise the priority case, and it toggles the enable between edges to observe the combinational interrupt path.

// File: rtl/rft_pkg.sv
package rft_pkg;

    localparam int unsigned DOTS_PER_LINE   = 341;
    localparam int unsigned LINES_PER_FRAME = 262;
    localparam int unsigned VISIBLE_LINES   = 240;
    localparam int unsigned VBLANK_LINE     = 241;
    localparam int unsigned FETCH_LAST_DOT  = 256;
    localparam int unsigned SPRITE_LAST_DOT = 320;

    typedef enum logic [1:0] {
        LC_VISIBLE = 2'd0,
        LC_IDLE    = 2'd1,
        LC_BLANK   = 2'd2,
        LC_PREP    = 2'd3
    } line_class_e;

    typedef enum logic [1:0] {
        WIN_NONE     = 2'd0,
        WIN_FETCH    = 2'd1,
        WIN_SPRITE   = 2'd2,
        WIN_PREFETCH = 2'd3
    } dot_window_e;

endpackage

// File: rtl/rft_counter.sv
module rft_counter #(
    parameter int unsigned DOTS  = rft_pkg::DOTS_PER_LINE,
    parameter int unsigned LINES = rft_pkg::LINES_PER_FRAME,
    localparam int unsigned DW   = $clog2(DOTS),
    localparam int unsigned LW   = $clog2(LINES)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    output logic [DW-1:0] dot_o,
    output logic [LW-1:0] line_o,
    output logic          wrap_o
);

    localparam logic [DW-1:0] DOT_MAX  = DW'(DOTS - 1);
    localparam logic [LW-1:0] LINE_MAX = LW'(LINES - 1);

    typedef struct packed {
        logic [DW-1:0] dot;
        logic [LW-1:0] line;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.dot == DOT_MAX) begin
            pos_d.dot = '0;
            if (pos_q.line == LINE_MAX) begin
                pos_d.line = '0;
            end else begin
                pos_d.line = pos_q.line + LW'(1);
            end
        end else begin
            pos_d.dot = pos_q.dot + DW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign dot_o  = pos_q.dot;
    assign line_o = pos_q.line;
    assign wrap_o = (pos_q.dot == DOT_MAX) && (pos_q.line == LINE_MAX);

    // R1: dot stays in range, steps by one, wraps after its last value
    assert_dot_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_q.dot <= DOT_MAX);
    assert_dot_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_q.dot != DOT_MAX) |=> (pos_q.dot == $past(pos_q.dot) + DW'(1)));
    assert_dot_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_q.dot == DOT_MAX) |=> (pos_q.dot == '0));

    // R2: line moves only at the end of a line and wraps after the last line
    assert_line_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_q.dot != DOT_MAX) |=> $stable(pos_q.line));
    assert_line_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_q.line <= LINE_MAX);
    assert_line_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (pos_q.line == '0));

endmodule

// File: rtl/rft_phase.sv
module rft_phase #(
    parameter int unsigned DOTS        = rft_pkg::DOTS_PER_LINE,
    parameter int unsigned LINES       = rft_pkg::LINES_PER_FRAME,
    parameter int unsigned VIS_LINES   = rft_pkg::VISIBLE_LINES,
    parameter int unsigned BLANK_LINE  = rft_pkg::VBLANK_LINE,
    parameter int unsigned FETCH_LAST  = rft_pkg::FETCH_LAST_DOT,
    parameter int unsigned SPRITE_LAST = rft_pkg::SPRITE_LAST_DOT,
    localparam int unsigned DW         = $clog2(DOTS),
    localparam int unsigned LW         = $clog2(LINES),
    localparam int unsigned PXW        = $clog2(FETCH_LAST),
    localparam int unsigned PYW        = $clog2(VIS_LINES)
) (
    input  logic [DW-1:0]  dot_i,
    input  logic [LW-1:0]  line_i,
    output logic           fetch_o,
    output logic           sprite_o,
    output logic           prefetch_o,
    output logic           visible_o,
    output logic [PXW-1:0] px_x_o,
    output logic [PYW-1:0] px_y_o,
    output logic           set_o,
    output logic           autoclr_o
);

    import rft_pkg::*;

    localparam logic [LW-1:0] L_IDLE   = LW'(VIS_LINES);
    localparam logic [LW-1:0] L_BLANK  = LW'(BLANK_LINE);
    localparam logic [LW-1:0] L_PREP   = LW'(LINES - 1);
    localparam logic [DW-1:0] D_FETCH  = DW'(FETCH_LAST);
    localparam logic [DW-1:0] D_SPRITE = DW'(SPRITE_LAST);

    line_class_e lclass;
    dot_window_e win;
    logic        rendering;

    always_comb begin
        if (line_i < L_IDLE) begin
            lclass = LC_VISIBLE;
        end else if (line_i == L_IDLE) begin
            lclass = LC_IDLE;
        end else if (line_i == L_PREP) begin
            lclass = LC_PREP;
        end else begin
            lclass = LC_BLANK;
        end
    end

    assign rendering = (lclass == LC_VISIBLE) || (lclass == LC_PREP);

    always_comb begin
        win = WIN_NONE;
        if (rendering && (dot_i != '0)) begin
            if (dot_i <= D_FETCH) begin
                win = WIN_FETCH;
            end else if (dot_i <= D_SPRITE) begin
                win = WIN_SPRITE;
            end else begin
                win = WIN_PREFETCH;
            end
        end
    end

    assign fetch_o    = (win == WIN_FETCH);
    assign sprite_o   = (win == WIN_SPRITE);
    assign prefetch_o = (win == WIN_PREFETCH);
    assign visible_o  = (win == WIN_FETCH) && (lclass == LC_VISIBLE);

    always_comb begin
        px_x_o = '0;
        px_y_o = '0;
        if (visible_o) begin
            px_x_o = PXW'(dot_i - DW'(1));
            px_y_o = PYW'(line_i);
        end
    end

    assign set_o     = (line_i == L_BLANK) && (dot_i == '0);
    assign autoclr_o = (lclass == LC_PREP) && (dot_i == DW'(1));

endmodule

// File: rtl/rft_vblank.sv
module rft_vblank (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic autoclr_i,
    input  logic clr_i,
    input  logic wrap_i,
    input  logic nmi_en_i,
    output logic vblank_o,
    output logic nmi_o,
    output logic frame_done_o
);

    typedef struct packed {
        logic flag;
        logic done;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = wrap_i;
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i || autoclr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vblank_o     = st_q.flag;
    assign nmi_o        = st_q.flag & nmi_en_i;
    assign frame_done_o = st_q.done;

    // R6: the start of blanking always leaves the flag set
    assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> vblank_o);
    // R7: a clear request empties the flag unless the set coincides
    assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i) |=> !vblank_o);
    // R8: the preparation line empties the flag
    assert_flag_auto_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        autoclr_i |=> !vblank_o);
    // R6/R7/R8: with no event the flag keeps its value
    assert_flag_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i && !clr_i && !autoclr_i) |=> $stable(vblank_o));
    // R9: no request without the flag
    assert_nmi_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_o |-> vblank_o);
    // R10: the frame pulse lasts one cycle and follows the wrap
    assert_done_after_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i |=> frame_done_o);
    assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |=> !frame_done_o);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int unsigned DOTS        = rft_pkg::DOTS_PER_LINE,
    parameter int unsigned LINES       = rft_pkg::LINES_PER_FRAME,
    parameter int unsigned VIS_LINES   = rft_pkg::VISIBLE_LINES,
    parameter int unsigned BLANK_LINE  = rft_pkg::VBLANK_LINE,
    parameter int unsigned FETCH_LAST  = rft_pkg::FETCH_LAST_DOT,
    parameter int unsigned SPRITE_LAST = rft_pkg::SPRITE_LAST_DOT,
    localparam int unsigned DW         = $clog2(DOTS),
    localparam int unsigned LW         = $clog2(LINES),
    localparam int unsigned PXW        = $clog2(FETCH_LAST),
    localparam int unsigned PYW        = $clog2(VIS_LINES)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           nmi_en_i,
    input  logic           vblank_clr_i,
    output logic [DW-1:0]  dot_o,
    output logic [LW-1:0]  line_o,
    output logic           fetch_o,
    output logic           sprite_o,
    output logic           prefetch_o,
    output logic           visible_o,
    output logic [PXW-1:0] px_x_o,
    output logic [PYW-1:0] px_y_o,
    output logic           vblank_o,
    output logic           nmi_o,
    output logic           frame_done_o
);

    logic wrap;
    logic blank_set;
    logic blank_autoclr;

    rft_counter #(
        .DOTS  (DOTS),
        .LINES (LINES)
    ) u_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .dot_o  (dot_o),
        .line_o (line_o),
        .wrap_o (wrap)
    );

    rft_phase #(
        .DOTS        (DOTS),
        .LINES       (LINES),
        .VIS_LINES   (VIS_LINES),
        .BLANK_LINE  (BLANK_LINE),
        .FETCH_LAST  (FETCH_LAST),
        .SPRITE_LAST (SPRITE_LAST)
    ) u_phase (
        .dot_i      (dot_o),
        .line_i     (line_o),
        .fetch_o    (fetch_o),
        .sprite_o   (sprite_o),
        .prefetch_o (prefetch_o),
        .visible_o  (visible_o),
        .px_x_o     (px_x_o),
        .px_y_o     (px_y_o),
        .set_o      (blank_set),
        .autoclr_o  (blank_autoclr)
    );

    rft_vblank u_vblank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .set_i        (blank_set),
        .autoclr_i    (blank_autoclr),
        .clr_i        (vblank_clr_i),
        .wrap_i       (wrap),
        .nmi_en_i     (nmi_en_i),
        .vblank_o     (vblank_o),
        .nmi_o        (nmi_o),
        .frame_done_o (frame_done_o)
    );

    // R4: no work window on the idle and blanking lines
    assert_idle_lines_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_o >= LW'(VIS_LINES) && line_o < LW'(LINES - 1))
            |-> !(fetch_o || sprite_o || prefetch_o));
    // R5: a visible pixel only ever lies inside the fetch window
    assert_visible_in_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        visible_o |-> fetch_o);
    // R10: the frame pulse coincides with the origin of the raster
    assert_done_at_origin_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |-> (dot_o == '0 && line_o == '0));
    // R6: the flag rises only at the second dot of the first blanking line
    assert_flag_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vblank_o) |-> (line_o == LW'(BLANK_LINE) && dot_o == DW'(1)));

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    logic       clk;
    logic       rst_n;
    logic       nmi_en;
    logic       vb_clr;
    logic [8:0] dot;
    logic [8:0] line;
    logic       fetch, sprite, prefetch, visible;
    logic [7:0] px_x, px_y;
    logic       vblank, nmi, frame_done;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit finished = 0;

    int exp_dot  = 0;
    int exp_line = 0;
    bit exp_vb   = 0;
    bit exp_done = 0;

    raster_timing_gen u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .nmi_en_i     (nmi_en),
        .vblank_clr_i (vb_clr),
        .dot_o        (dot),
        .line_o       (line),
        .fetch_o      (fetch),
        .sprite_o     (sprite),
        .prefetch_o   (prefetch),
        .visible_o    (visible),
        .px_x_o       (px_x),
        .px_y_o       (px_y),
        .vblank_o     (vblank),
        .nmi_o        (nmi),
        .frame_done_o (frame_done)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 195000 && !finished) begin
            finished = 1;
            failures = failures + 1;
            $display("FAIL watchdog R1 cycles=%0d expected below 195000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s at line %0d dot %0d: actual=%0d expected=%0d",
                     req, what, exp_line, exp_dot, act, exp);
        end
    endtask

    task automatic check_all();
        bit rend, e_fetch, e_sprite, e_pre, e_vis;
        rend     = (exp_line < 240) || (exp_line == 261);
        e_fetch  = rend && exp_dot >= 1 && exp_dot <= 256;
        e_sprite = rend && exp_dot >= 257 && exp_dot <= 320;
        e_pre    = rend && exp_dot >= 321;
        e_vis    = (exp_line < 240) && exp_dot >= 1 && exp_dot <= 256;
        chk(int'(dot) == exp_dot, "R1", "dot", int'(dot), exp_dot);
        chk(int'(line) == exp_line, "R2", "line", int'(line), exp_line);
        chk(fetch == e_fetch, "R4", "fetch", int'(fetch), int'(e_fetch));
        chk(sprite == e_sprite, "R4", "sprite", int'(sprite), int'(e_sprite));
        chk(prefetch == e_pre, "R4", "prefetch", int'(prefetch), int'(e_pre));
        chk(visible == e_vis, "R5", "visible", int'(visible), int'(e_vis));
        chk(int'(px_x) == (e_vis ? exp_dot - 1 : 0), "R5", "px_x",
            int'(px_x), e_vis ? exp_dot - 1 : 0);
        chk(int'(px_y) == (e_vis ? exp_line : 0), "R5", "px_y",
            int'(px_y), e_vis ? exp_line : 0);
        chk(vblank == exp_vb, "R6", "vblank", int'(vblank), int'(exp_vb));
        chk(nmi == (exp_vb & nmi_en), "R9", "nmi", int'(nmi), int'(exp_vb & nmi_en));
        chk(frame_done == exp_done, "R10", "frame_done", int'(frame_done), int'(exp_done));
    endtask

    task automatic tick();
        int  pd, pl;
        bit  pclr;
        pd   = exp_dot;
        pl   = exp_line;
        pclr = vb_clr;
        @(posedge clk);
        #1;
        exp_done = (pd == 340) && (pl == 261);
        if (pd == 340) begin
            exp_dot  = 0;
            exp_line = (pl == 261) ? 0 : pl + 1;
        end else begin
            exp_dot = pd + 1;
        end
        if (pl == 241 && pd == 0) exp_vb = 1;
        else if (pclr || (pl == 261 && pd == 1)) exp_vb = 0;
        check_all();
    endtask

    task automatic run_to(input int l, input int d);
        while (!(exp_line == l && exp_dot == d)) tick();
    endtask

    task automatic t_reset();
        rst_n  = 1'b0;
        nmi_en = 1'b1;
        vb_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(dot == 9'd0 && line == 9'd0, "R3", "counters in reset",
            int'(dot) + int'(line), 0);
        chk(!vblank && !nmi && !frame_done, "R3", "flags in reset",
            int'(vblank) + int'(nmi) + int'(frame_done), 0);
        rst_n = 1'b1;
        #1;
        chk(!frame_done && !nmi, "R3", "after release",
            int'(frame_done) + int'(nmi), 0);
        check_all();
        nmi_en = 1'b0;
    endtask

    task automatic t_first_line();
        run_to(1, 0);
        chk(line == 9'd1 && dot == 9'd0, "R2", "line step", int'(line), 1);
    endtask

    task automatic t_idle_line();
        run_to(240, 200);
        chk(!fetch && !visible, "R4", "idle line window", int'(fetch), 0);
    endtask

    task automatic t_blank_set_and_enable();
        run_to(241, 0);
        chk(!vblank, "R6", "flag before set", int'(vblank), 0);
        tick();
        chk(vblank, "R6", "flag at 241/1", int'(vblank), 1);
        chk(!nmi, "R9", "nmi disabled", int'(nmi), 0);
        nmi_en = 1'b1;
        #1;
        chk(nmi, "R9", "late enable raises nmi", int'(nmi), 1);
        nmi_en = 1'b0;
        #1;
        chk(!nmi, "R9", "disable drops nmi", int'(nmi), 0);
        nmi_en = 1'b1;
    endtask

    task automatic t_auto_clear();
        run_to(261, 1);
        chk(vblank && nmi, "R8", "flag held to 261/1", int'(vblank), 1);
        tick();
        chk(!vblank && !nmi, "R8", "flag cleared at 261/2", int'(vblank), 0);
    endtask

    task automatic t_frame_wrap();
        run_to(261, 340);
        chk(!frame_done, "R10", "no pulse before wrap", int'(frame_done), 0);
        tick();
        chk(frame_done && dot == 9'd0 && line == 9'd0, "R10", "pulse at origin",
            int'(frame_done), 1);
        tick();
        chk(!frame_done, "R10", "pulse one cycle", int'(frame_done), 0);
    endtask

    task automatic t_clear_priority();
        run_to(240, 300);
        vb_clr = 1'b1;
        run_to(241, 0);
        tick();
        chk(vblank, "R7", "set wins over clear", int'(vblank), 1);
        vb_clr = 1'b0;
        run_to(241, 20);
        vb_clr = 1'b1;
        tick();
        vb_clr = 1'b0;
        chk(!vblank && !nmi, "R7", "clear pulse empties flag", int'(vblank), 0);
        run_to(241, 25);
        chk(!vblank, "R7", "flag stays clear", int'(vblank), 0);
    endtask

    initial begin
        t_reset();
        t_first_line();
        t_idle_line();
        t_blank_set_and_enable();
        t_auto_clear();
        t_frame_wrap();
        t_clear_priority();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule